// File: doc/BRIEF.md
# Tick-Scheduled Instruction Control Sequencer

This block turns an opcode into a timed burst of control strobes. Each opcode has an entry in an internal microcode ROM. The entry holds a length n and, for every control signal, the tick number on which that signal must fire. Once an instruction is accepted, a tick counter runs 1, 2, … n. A bank of comparators, one per control signal, raises a signal's strobe in the cycle that matches its programmed tick. A done pulse marks tick n.

A tick value of zero means the signal never fires for that opcode. Opcodes 1 to 15 are regular instructions. Opcode 0 is an empty one-tick instruction. Every opcode above 15 is a one-tick clear-all, used while the surrounding machine is being brought up. The two highest-numbered strobes drive a two-phase memory write: the first clears the target word and the second, on the following tick, presents the data. Only the store opcode schedules them.

The ROM contents are computed when the design is built, from the rules listed below.

Top module: `tick_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it was high, `strobe_o` is all zero and `done_o` is low. A `start_i` seen during reset launches nothing.
- R2: Let E0 be the rising edge that accepts a start. The outputs for tick t are visible after edge E0+t. For opcodes 1..15 the instruction lasts n = (opcode mod 4) + 3 ticks. `done_o` is high on tick n only.
- R3: For a regular opcode op (1..15) and a signal index s below NUM_SIG-2: strobe s fires on tick ((s+op) mod n)+1, unless (s+op) mod 3 is 0, in which case it never fires.
- R4: Within one instruction, each strobe is high for at most one cycle. After the done cycle, with no new start, all outputs return to zero.
- R5: For the store opcode 11 (n = 6), the write-clear strobe at index NUM_SIG-2 fires on tick 5. The write-data strobe at index NUM_SIG-1 fires on tick 6. No other opcode fires either of these two strobes.
- R6: Any opcode above 15 is a one-tick clear-all. All strobes 0..NUM_SIG-3 fire together on tick 1, with `done_o` in the same cycle.
- R7: Opcode 0 lasts one tick, fires no strobe, and raises `done_o`.
- R8: A `start_i` sampled while an instruction is running, on any tick other than its last, is ignored. The running instruction's strobes continue unchanged, and the outputs are idle after its done cycle.
- R9: A `start_i` sampled on the last tick of an instruction is accepted. The new instruction's tick 1 follows directly after the old one's done cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the instruction given on `opcode_i` |
| opcode_i | input | OP_W | Opcode, sampled together with `start_i` |
| strobe_o | output | NUM_SIG | One-cycle control strobes, registered |
| done_o | output | 1 | High on the last tick of an instruction, registered |

## Verification
The hardest case to reach is the handover between two instructions. A start must land exactly on the old instruction's last tick, which the ports reveal only through timing, and a start one tick earlier must be dropped. The bench counts edges from the accepting edge and drives a second start on the last tick of a five-tick instruction. The expected result is the old done cycle followed at once by a clear-all vector. A separate run drives a start on tick 2 of a four-tick instruction and checks that the original schedule is unchanged.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int unsigned SEQ_NUM_SIG      = 32;
  localparam int unsigned SEQ_TICK_W       = 4;
  localparam int unsigned SEQ_OP_W         = 5;
  localparam int unsigned SEQ_STORE_OP     = 11;
  localparam int unsigned SEQ_LAST_REGULAR = 15;

  // Number of ticks an opcode occupies.
  function automatic int unsigned uc_len(int unsigned op);
    if (op == 0 || op > SEQ_LAST_REGULAR) return 1;
    return (op % 4) + 3;
  endfunction

  // Tick on which signal sig fires for opcode op; 0 = never.
  function automatic int unsigned uc_tick(int unsigned op, int unsigned sig,
                                          int unsigned nsig, int unsigned store_op);
    int unsigned n;
    n = uc_len(op);
    if (op == 0) return 0;
    if (op > SEQ_LAST_REGULAR) return (sig < nsig - 2) ? 1 : 0;
    if (sig == nsig - 2) return (op == store_op) ? n - 1 : 0;
    if (sig == nsig - 1) return (op == store_op) ? n : 0;
    if (((sig + op) % 3) == 0) return 0;
    return ((sig + op) % n) + 1;
  endfunction

endpackage

// File: rtl/seq_ucode_rom.sv
module seq_ucode_rom #(
  parameter int unsigned NUM_SIG  = seq_pkg::SEQ_NUM_SIG,
  parameter int unsigned TICK_W   = seq_pkg::SEQ_TICK_W,
  parameter int unsigned OP_W     = seq_pkg::SEQ_OP_W,
  parameter int unsigned STORE_OP = seq_pkg::SEQ_STORE_OP
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [OP_W-1:0]           rd_addr,
  output logic [NUM_SIG*TICK_W-1:0] tick_tab_o,
  output logic [TICK_W-1:0]         len_o
);
  localparam int unsigned DEPTH  = 1 << OP_W;
  localparam int unsigned TAB_W  = NUM_SIG * TICK_W;
  localparam int unsigned WORD_W = TAB_W + TICK_W;

  function automatic logic [WORD_W-1:0] build_word(int unsigned op);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned s = 0; s < NUM_SIG; s++)
      w[s*TICK_W +: TICK_W] = TICK_W'(seq_pkg::uc_tick(op, s, NUM_SIG, STORE_OP));
    w[TAB_W +: TICK_W] = TICK_W'(seq_pkg::uc_len(op));
    return w;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] word_q;

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) mem[i] = build_word(i);
  end

  // Registered read port, block-RAM style.
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (rd_en) word_q <= mem[rd_addr];
  end

  assign tick_tab_o = word_q[TAB_W-1:0];
  assign len_o      = word_q[TAB_W +: TICK_W];
endmodule

// File: rtl/seq_tick_ctr.sv
module seq_tick_ctr #(
  parameter int unsigned TICK_W = seq_pkg::SEQ_TICK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [TICK_W-1:0] len_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              accept_o,
  output logic              last_o
);
  logic [TICK_W-1:0] tick_q;

  assign last_o   = (tick_q != '0) && (tick_q == len_i);
  assign accept_o = start_i && ((tick_q == '0) || last_o);

  always_ff @(posedge clk) begin
    if (rst)                 tick_q <= '0;
    else if (accept_o)       tick_q <= TICK_W'(1);
    else if (last_o)         tick_q <= '0;
    else if (tick_q != '0)   tick_q <= tick_q + TICK_W'(1);
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/seq_strobe_bank.sv
module seq_strobe_bank #(
  parameter int unsigned NUM_SIG = seq_pkg::SEQ_NUM_SIG,
  parameter int unsigned TICK_W  = seq_pkg::SEQ_TICK_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [TICK_W-1:0]         tick_i,
  input  logic [NUM_SIG*TICK_W-1:0] tick_tab_i,
  input  logic                      last_i,
  output logic [NUM_SIG-1:0]        strobe_o,
  output logic                      done_o
);
  logic [NUM_SIG-1:0] hit;
  logic [NUM_SIG-1:0] strobe_q;
  logic               done_q;

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_cmp
    logic [TICK_W-1:0] at;
    assign at     = tick_tab_i[g*TICK_W +: TICK_W];
    assign hit[g] = (at != '0) && (at == tick_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= '0;
      done_q   <= 1'b0;
    end else begin
      strobe_q <= hit;
      done_q   <= last_i;
    end
  end

  assign strobe_o = strobe_q;
  assign done_o   = done_q;
endmodule

// File: rtl/tick_sequencer.sv
module tick_sequencer #(
  parameter int unsigned NUM_SIG  = seq_pkg::SEQ_NUM_SIG,
  parameter int unsigned TICK_W   = seq_pkg::SEQ_TICK_W,
  parameter int unsigned OP_W     = seq_pkg::SEQ_OP_W,
  parameter int unsigned STORE_OP = seq_pkg::SEQ_STORE_OP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [OP_W-1:0]    opcode_i,
  output logic [NUM_SIG-1:0] strobe_o,
  output logic               done_o
);
  logic [NUM_SIG*TICK_W-1:0] tab_w;
  logic [TICK_W-1:0]         len_w;
  logic [TICK_W-1:0]         tick_w;
  logic                      accept_w;
  logic                      last_w;

  seq_ucode_rom #(
    .NUM_SIG(NUM_SIG), .TICK_W(TICK_W), .OP_W(OP_W), .STORE_OP(STORE_OP)
  ) u_rom (
    .clk(clk), .rst(rst), .rd_en(accept_w), .rd_addr(opcode_i),
    .tick_tab_o(tab_w), .len_o(len_w)
  );

  seq_tick_ctr #(.TICK_W(TICK_W)) u_ctr (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_w),
    .tick_o(tick_w), .accept_o(accept_w), .last_o(last_w)
  );

  seq_strobe_bank #(.NUM_SIG(NUM_SIG), .TICK_W(TICK_W)) u_bank (
    .clk(clk), .rst(rst), .tick_i(tick_w), .tick_tab_i(tab_w),
    .last_i(last_w), .strobe_o(strobe_o), .done_o(done_o)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned NUM_SIG = seq_pkg::SEQ_NUM_SIG,
  parameter int unsigned TICK_W  = seq_pkg::SEQ_TICK_W
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SIG-1:0] strobe_o,
  input logic               done_o,
  input logic [TICK_W-1:0]  tick_q,
  input logic [TICK_W-1:0]  len_q
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (strobe_o == '0 && !done_o));                                   // R1

  AST_TICK_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
    (tick_q != '0) |-> (tick_q <= len_q));                                 // R2

  AST_DONE_ON_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(tick_q != '0 && tick_q == len_q));             // R2

  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> ((strobe_o & $past(strobe_o)) == '0));                     // R4

  AST_WRITE_DATA_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobe_o[NUM_SIG-1] |-> $past(strobe_o[NUM_SIG-2]));                   // R5

  AST_CLEAR_ALL_IS_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    ($countones(strobe_o) == NUM_SIG-2) |-> done_o);                       // R6
endmodule

bind tick_sequencer seq_checker #(.NUM_SIG(NUM_SIG), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .strobe_o(strobe_o), .done_o(done_o),
  .tick_q(tick_w), .len_q(len_w)
);

// File: tb/sim_tick_sequencer.sv
module sim_tick_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int OPW = 5;
  localparam int NOPS = 14;
  localparam int unsigned OPS [NOPS] = '{1, 2, 3, 4, 5, 6, 7, 9, 11, 13, 15, 16, 31, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [OPW-1:0] opcode_i = '0;
  logic [NS-1:0] strobe_o;
  logic done_o;

  int n_chk = 0;
  int n_bad = 0;

  tick_sequencer u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .strobe_o(strobe_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int e_len(int op);
    if (op == 0 || op > 15) return 1;
    return (op % 4) + 3;
  endfunction

  function automatic logic [NS-1:0] e_vec(int op, int t);
    logic [NS-1:0] v;
    int n;
    v = '0;
    n = e_len(op);
    if (op > 15) begin
      for (int s = 0; s < NS-2; s++) v[s] = (t == 1);
    end else if (op != 0) begin
      for (int s = 0; s < NS-2; s++)
        if (((s + op) % 3) != 0 && (((s + op) % n) + 1) == t) v[s] = 1'b1;
      if (op == 11) begin
        v[NS-2] = (t == n - 1);
        v[NS-1] = (t == n);
      end
    end
    return v;
  endfunction

  function automatic string tag_of(int op);
    if (op == 0) return "R7";
    if (op > 15) return "R6";
    if (op == 11) return "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NS:0] act, input logic [NS:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_tick(input int op, input int t, input string req);
    logic [NS-1:0] ev;
    ev = e_vec(op, t);
    chk(strobe_o == ev, req, {1'b0, strobe_o}, {1'b0, ev});
    chk(done_o == (t == e_len(op)), "R2 done", {{NS{1'b0}}, done_o}, {{NS{1'b0}}, t == e_len(op)});
  endtask

  task automatic check_idle(input string req);
    chk(strobe_o == '0 && !done_o, req, {done_o, strobe_o}, '0);
  endtask

  // Drive start for one edge; returns at the negedge just after acceptance.
  task automatic launch(input int op);
    start_i = 1'b1;
    opcode_i = OPW'(op);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(input int op);
    launch(op);
    for (int t = 1; t <= e_len(op); t++) begin
      @(negedge clk);
      check_tick(op, t, tag_of(op));
    end
    @(negedge clk);
    check_idle("R4 idle after done");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: start during reset launches nothing
    @(negedge clk);
    start_i = 1'b1;
    opcode_i = 5'd16;
    @(negedge clk);
    @(negedge clk);
    check_idle("R1 during reset");
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    @(negedge clk);
    check_idle("R1 no launch");

    // Table walk
    for (int i = 0; i < NOPS; i++) begin
      @(negedge clk);
      run_op(int'(OPS[i]));
    end

    // R8: start on tick 2 of a 4-tick op (1) is ignored
    @(negedge clk);
    launch(1);
    @(negedge clk);
    check_tick(1, 1, "R8");
    start_i = 1'b1;
    opcode_i = 5'd16;
    @(negedge clk);
    start_i = 1'b0;
    check_tick(1, 2, "R8");
    for (int t = 3; t <= 4; t++) begin
      @(negedge clk);
      check_tick(1, t, "R8");
    end
    @(negedge clk);
    check_idle("R8 no late launch");

    // R9: start on last tick of op 2 (n=5) chains clear-all directly
    @(negedge clk);
    launch(2);
    for (int t = 1; t <= 4; t++) begin
      @(negedge clk);
      check_tick(2, t, "R9");
    end
    start_i = 1'b1;
    opcode_i = 5'd16;
    @(negedge clk);
    start_i = 1'b0;
    check_tick(2, 5, "R9");
    @(negedge clk);
    check_tick(16, 1, "R9 chained");
    @(negedge clk);
    check_idle("R9 end");

    // R1: reset mid-instruction clears outputs
    @(negedge clk);
    launch(3);
    @(negedge clk);
    check_tick(3, 1, "R3");
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 mid reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after mid reset");
    @(negedge clk);
    check_idle("R1 stays idle");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule